// File: doc/BRIEF.md
# Down-Counting Timer with PWM and Interrupt Pulse

This block is a single timer unit. A 32-bit counter is loaded with a period value and then steps down by one on each count enable. The count enable comes from a local prescaler, from a cascade input fed by an upstream unit's terminal pulse, or from a software strobe. A compare value is captured at every load. The PWM output rises when the count steps onto the compare value and falls when the count steps onto zero. The zero crossing also raises an interrupt and emits a one-cycle terminal pulse for a downstream unit.

Software controls the unit through a synchronous write port and a combinational read port. The unit has four counting modes: one-shot, auto-reload, free-running with wrap, and software event counting. The interrupt is either a fixed pulse of 2, 4 or 8 clocks or a level that holds until software clears it, and its polarity is selectable. A pause bit freezes the count. The readable count register either follows the counter or holds the last value seen before live read-back was turned off.

Register map: address 0 is configuration, 1 is command, 2 is the event strobe, 3 is the period, 4 is the count view (read-only) and 5 is the compare value. Any other address reads as zero.

Top module: `dcnt_pwm_timer`

## Requirements
- R1: After reset every register is zero, the count view reads 0, the PWM output and the terminal pulse are low, and the interrupt output is low.
- R2: Writing the command register (address 1) with bit 0 set is a self-clearing reload strobe. On the second clock edge after the write, the count becomes the period (address 3), the compare value (address 5) is captured, the PWM output goes low and counting restarts.
- R3: In modes other than free-running, the PWM output goes high when the count steps onto the captured compare value. In every mode it goes low when the count steps onto 0, and in free-running mode it never goes high.
- R4: When the count steps onto 0, the interrupt becomes active on that edge. The width code in configuration bits [7:6] selects its length: code 1 gives 2 clocks, code 2 gives 4 clocks, code 3 gives 8 clocks, and code 0 holds it until a write to command bit 2 clears it one edge later. Configuration bit 5 set makes the output active-low.
- R5: The mode code sits in configuration bits [4:2]. Code 0 stops at zero. Code 1 reloads the period and compare on the next step after zero. Code 2 steps from 0 to 0xFFFFFFFF. Code 3 is event counting and stops at zero. Codes 4 to 7 never step.
- R6: The prescaler code sits in configuration bits [1:0], and codes 0 to 3 give one step every 1, 2, 4 or 16 clocks, measured from the load.
- R7: In mode 3, each write of bit 0 to the event register (address 2) produces exactly one decrement, two edges after the write. The strobe clears itself, so the count does not move without another write.
- R8: While command bit 1 (pause) is set, the count and the prescaler hold their values.
- R9: While command bit 3 is 1, the count view (address 4) follows the live count. While it is 0, the view holds the count captured on the edge that cleared the bit.
- R10: With configuration bit 8 set, each clock with the cascade input high is one step. The terminal output is a one-clock pulse on every step onto zero and is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data (combinational) |
| cascadeIn | input | 1 | Step enable from an upstream unit |
| pwmOut | output | 1 | PWM waveform |
| irqOut | output | 1 | Interrupt, polarity per configuration |
| tcOut | output | 1 | One-clock terminal pulse for a downstream unit |

## Verification
The assertions assume that the cascade input and the write port are synchronous to the clock. They also assume that a reload is the only way a new period reaches the counter, so a period write on its own never changes the count. The stimulus changes inputs only on falling edges. It reprograms the configuration only after counting has settled or right before a reload, and it drives the cascade input only while the cascade source is selected. A behavioural model in the bench tracks every output and the selected read value on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADR_CFG    = 0;
  localparam int ADR_CMD    = 1;
  localparam int ADR_EVT    = 2;
  localparam int ADR_PERIOD = 3;
  localparam int ADR_COUNT  = 4;
  localparam int ADR_CMP    = 5;

  localparam logic [2:0] MODE_ONCE  = 3'd0;
  localparam logic [2:0] MODE_AUTO  = 3'd1;
  localparam logic [2:0] MODE_FREE  = 3'd2;
  localparam logic [2:0] MODE_EVENT = 3'd3;

  typedef struct packed {
    logic reload;
    logic step;
    logic irqClear;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              cascadeIn,
  input  logic              running,
  input  logic [CNT_W-1:0]  countView,
  output tmrStrobe_t        strb,
  output logic [2:0]        mode,
  output logic [1:0]        irqWidth,
  output logic              irqPol,
  output logic              liveRead,
  output logic              pauseQ,
  output logic [CNT_W-1:0]  periodQ,
  output logic [CNT_W-1:0]  compareQ
);
  localparam int PRE_W = 4;

  logic [1:0]       preCodeQ;
  logic             cascSelQ;
  logic             reloadP, clearP, eventP;
  logic [PRE_W-1:0] preCnt, preLimit;
  logic             canCount, prescaleRun, tick;

  always_comb begin
    case (preCodeQ)
      2'd0:    preLimit = PRE_W'(0);
      2'd1:    preLimit = PRE_W'(1);
      2'd2:    preLimit = PRE_W'(3);
      default: preLimit = PRE_W'(15);
    endcase
  end

  assign canCount    = running && !pauseQ;
  assign prescaleRun = canCount && !cascSelQ && (mode <= MODE_FREE);
  assign tick        = (preCnt >= preLimit);

  always_comb begin
    strb.reload   = reloadP;
    strb.irqClear = clearP;
    if (mode == MODE_EVENT)     strb.step = canCount && eventP;
    else if (mode > MODE_FREE)  strb.step = 1'b0;
    else if (cascSelQ)          strb.step = canCount && cascadeIn;
    else                        strb.step = canCount && tick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCodeQ <= '0;
      mode     <= '0;
      irqPol   <= 1'b0;
      irqWidth <= '0;
      cascSelQ <= 1'b0;
      pauseQ   <= 1'b0;
      liveRead <= 1'b0;
      periodQ  <= '0;
      compareQ <= '0;
      reloadP  <= 1'b0;
      clearP   <= 1'b0;
      eventP   <= 1'b0;
    end else begin
      reloadP <= 1'b0;
      clearP  <= 1'b0;
      eventP  <= 1'b0;
      if (wrEn) begin
        case (wrAddr)
          ADDR_W'(ADR_CFG): begin
            preCodeQ <= wrData[1:0];
            mode     <= wrData[4:2];
            irqPol   <= wrData[5];
            irqWidth <= wrData[7:6];
            cascSelQ <= wrData[8];
          end
          ADDR_W'(ADR_CMD): begin
            reloadP  <= wrData[0];
            pauseQ   <= wrData[1];
            clearP   <= wrData[2];
            liveRead <= wrData[3];
          end
          ADDR_W'(ADR_EVT):    eventP   <= wrData[0];
          ADDR_W'(ADR_PERIOD): periodQ  <= wrData;
          ADDR_W'(ADR_CMP):    compareQ <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            preCnt <= '0;
    else if (reloadP)     preCnt <= '0;
    else if (prescaleRun) preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(ADR_CFG):    rdData[8:0] = {cascSelQ, irqWidth, irqPol, mode, preCodeQ};
      ADDR_W'(ADR_CMD):    rdData[3:0] = {liveRead, 1'b0, pauseQ, 1'b0};
      ADDR_W'(ADR_PERIOD): rdData = periodQ;
      ADDR_W'(ADR_COUNT):  rdData = countView;
      ADDR_W'(ADR_CMP):    rdData = compareQ;
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [2:0]       mode,
  input  logic [1:0]       irqWidth,
  input  logic             irqPol,
  input  logic             liveRead,
  input  logic [CNT_W-1:0] periodQ,
  input  logic [CNT_W-1:0] compareQ,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic             running,
  output logic [CNT_W-1:0] countView,
  output logic             pwmOut,
  output logic             irqOut,
  output logic             tcOut
);
  localparam int IRQ_W = 3;

  logic [CNT_W-1:0] cntN, cmpN, snapQ;
  logic             runN, pwmN, fire;
  logic             irqAct;
  logic [IRQ_W-1:0] irqLeft, irqLen;

  always_comb begin
    cntN = countQ;
    cmpN = cmpQ;
    runN = running;
    pwmN = pwmOut;
    fire = 1'b0;
    if (strb.reload) begin
      cntN = periodQ;
      cmpN = compareQ;
      runN = 1'b1;
      pwmN = 1'b0;
    end else if (strb.step) begin
      if (countQ == '0) begin
        if (mode == MODE_AUTO) begin
          cntN = periodQ;
          cmpN = compareQ;
          pwmN = 1'b0;
        end else if (mode == MODE_FREE) begin
          cntN = countQ - 1'b1;
        end else begin
          runN = 1'b0;
        end
      end else begin
        cntN = countQ - 1'b1;
        if (cntN == cmpQ && mode != MODE_FREE) pwmN = 1'b1;
        if (cntN == '0) begin
          pwmN = 1'b0;
          fire = 1'b1;
          if (mode == MODE_ONCE || mode == MODE_EVENT) runN = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      cmpQ    <= '0;
      running <= 1'b0;
      pwmOut  <= 1'b0;
      tcOut   <= 1'b0;
      snapQ   <= '0;
    end else begin
      countQ  <= cntN;
      cmpQ    <= cmpN;
      running <= runN;
      pwmOut  <= pwmN;
      tcOut   <= fire;
      if (liveRead) snapQ <= countQ;
    end
  end

  always_comb begin
    case (irqWidth)
      2'd1:    irqLen = IRQ_W'(1);
      2'd2:    irqLen = IRQ_W'(3);
      2'd3:    irqLen = IRQ_W'(7);
      default: irqLen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqAct  <= 1'b0;
      irqLeft <= '0;
    end else if (fire) begin
      irqAct  <= 1'b1;
      irqLeft <= irqLen;
    end else if (strb.irqClear) begin
      irqAct  <= 1'b0;
    end else if (irqAct && irqWidth != 2'd0) begin
      if (irqLeft == '0) irqAct <= 1'b0;
      else               irqLeft <= irqLeft - 1'b1;
    end
  end

  assign countView = liveRead ? countQ : snapQ;
  assign irqOut    = irqAct ^ irqPol;
endmodule

// File: rtl/dcnt_pwm_timer.sv
module dcnt_pwm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              cascadeIn,
  output logic              pwmOut,
  output logic              irqOut,
  output logic              tcOut
);
  tmrStrobe_t       strb;
  logic [2:0]       modeQ;
  logic [1:0]       widthQ;
  logic             polQ, liveQ, pauseQ, runQ;
  logic [CNT_W-1:0] periodQ, compareQ, countQ, cmpQ, countView;

  tmr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cascadeIn(cascadeIn),
    .running(runQ), .countView(countView), .strb(strb), .mode(modeQ),
    .irqWidth(widthQ), .irqPol(polQ), .liveRead(liveQ), .pauseQ(pauseQ),
    .periodQ(periodQ), .compareQ(compareQ)
  );

  tmr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(modeQ), .irqWidth(widthQ),
    .irqPol(polQ), .liveRead(liveQ), .periodQ(periodQ), .compareQ(compareQ),
    .countQ(countQ), .cmpQ(cmpQ), .running(runQ), .countView(countView),
    .pwmOut(pwmOut), .irqOut(irqOut), .tcOut(tcOut)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reload,
  input logic             pauseQ,
  input logic [2:0]       modeQ,
  input logic             polQ,
  input logic             runQ,
  input logic [CNT_W-1:0] periodQ,
  input logic [CNT_W-1:0] countQ,
  input logic [CNT_W-1:0] cmpQ,
  input logic             pwmOut,
  input logic             irqOut,
  input logic             tcOut
);
  // R2
  reload_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> (countQ == $past(periodQ)));

  // R3
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (countQ == cmpQ));

  // R3
  pwm_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwmOut) |-> (countQ == '0 || $past(reload)));

  // R4
  irq_at_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcOut |-> (irqOut != polQ));

  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'd0 && !runQ && !reload) |=> $stable(countQ));

  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pauseQ && !reload) |=> $stable(countQ));

  // R10
  tc_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcOut |=> !tcOut);
endmodule

bind dcnt_pwm_timer tmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .reload(strb.reload), .pauseQ(pauseQ),
  .modeQ(modeQ), .polQ(polQ), .runQ(runQ), .periodQ(periodQ),
  .countQ(countQ), .cmpQ(cmpQ), .pwmOut(pwmOut), .irqOut(irqOut),
  .tcOut(tcOut)
);

// File: tb/dcnt_pwm_timer_tb.sv
module dcnt_pwm_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = 3'd4;
  logic [31:0] rdData;
  logic        cascadeIn = 1'b0;
  logic        pwmOut, irqOut, tcOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dcnt_pwm_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cascadeIn(cascadeIn),
    .pwmOut(pwmOut), .irqOut(irqOut), .tcOut(tcOut)
  );

  // behavioural reference model
  logic [1:0]  mPre, mWid;
  logic [2:0]  mMode;
  logic        mPol, mCasc, mPause, mLive, mLoadP, mClrP, mEvtP;
  logic [31:0] mPeriod, mCmpReg, mCount, mCmp, mSnap;
  logic        mRun, mPwm, mIrq, mTc;
  int          mPc, mLeft;

  function automatic int limitOf(input logic [1:0] c);
    return (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 3 : 15;
  endfunction

  function automatic logic [31:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return {23'd0, mCasc, mWid, mPol, mMode, mPre};
      3'd1: return {28'd0, mLive, 1'b0, mPause, 1'b0};
      3'd3: return mPeriod;
      3'd4: return mLive ? mCount : mSnap;
      3'd5: return mCmpReg;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mWid = 0; mMode = 0; mPol = 0; mCasc = 0; mPause = 0; mLive = 0;
      mLoadP = 0; mClrP = 0; mEvtP = 0; mPeriod = 0; mCmpReg = 0; mCount = 0;
      mCmp = 0; mSnap = 0; mRun = 0; mPwm = 0; mIrq = 0; mTc = 0; mPc = 0; mLeft = 0;
    end else begin
      automatic int  lim = limitOf(mPre);
      automatic bit  go = mRun && !mPause;
      automatic bit  st = 0;
      automatic bit  fire = 0;
      if (mMode == 3)      st = go && mEvtP;
      else if (mMode > 3)  st = 0;
      else if (mCasc)      st = go && cascadeIn;
      else                 st = go && (mPc >= lim);
      if (mLoadP) mPc = 0;
      else if (go && !mCasc && mMode <= 2) mPc = (mPc >= lim) ? 0 : mPc + 1;
      if (mLive) mSnap = mCount;
      if (mLoadP) begin
        mCount = mPeriod; mCmp = mCmpReg; mRun = 1; mPwm = 0;
      end else if (st) begin
        if (mCount == 0) begin
          if (mMode == 1) begin mCount = mPeriod; mCmp = mCmpReg; mPwm = 0; end
          else if (mMode == 2) mCount = 32'hFFFF_FFFF;
          else mRun = 0;
        end else begin
          mCount = mCount - 1;
          if (mCount == mCmp && mMode != 2) mPwm = 1;
          if (mCount == 0) begin
            mPwm = 0; fire = 1;
            if (mMode == 0 || mMode == 3) mRun = 0;
          end
        end
      end
      if (fire) begin
        mIrq = 1;
        mLeft = (mWid == 0) ? 0 : (2 << (mWid - 1)) - 1;
        if (mWid == 3) mLeft = 7;
      end else if (mClrP) mIrq = 0;
      else if (mIrq && mWid != 0) begin
        if (mLeft == 0) mIrq = 0; else mLeft = mLeft - 1;
      end
      mTc = fire;
      mLoadP = 0; mClrP = 0; mEvtP = 0;
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mPre = wrData[1:0]; mMode = wrData[4:2]; mPol = wrData[5];
                      mWid = wrData[7:6]; mCasc = wrData[8]; end
          3'd1: begin mLoadP = wrData[0]; mPause = wrData[1]; mClrP = wrData[2];
                      mLive = wrData[3]; end
          3'd2: mEvtP = wrData[0];
          3'd3: mPeriod = wrData;
          3'd5: mCmpReg = wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      #1;
      check(pwmOut == mPwm, "R3 pwm", 32'(pwmOut), 32'(mPwm));
      check(irqOut == (mIrq ^ mPol), "R4 irq", 32'(irqOut), 32'(mIrq ^ mPol));
      check(tcOut == mTc, "R10 tc", 32'(tcOut), 32'(mTc));
      check(rdData == expRd(rdAddr), "R9 read", rdData, expRd(rdAddr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkCount(input logic [31:0] exp, input string req);
    #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  initial begin
    logic [31:0] held;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    #1;
    check(rdData == 0, "R1 count", rdData, 0);
    check(pwmOut == 0, "R1 pwm", 32'(pwmOut), 0);
    check(irqOut == 0, "R1 irq", 32'(irqOut), 0);
    check(tcOut == 0, "R1 tc", 32'(tcOut), 0);
    @(negedge clk);

    // auto-reload, div 1, width 2 clocks
    wr(3, 5); wr(5, 2);
    wr(0, (1 << 2) | (1 << 6));
    wr(1, 32'h9);
    idle(1); checkCount(5, "R2 reload");
    idle(3); #1; check(pwmOut == 1, "R3 pwm high at compare", 32'(pwmOut), 1);
    idle(2); #1;
    check(pwmOut == 0, "R3 pwm low at zero", 32'(pwmOut), 0);
    check(irqOut == 1, "R4 irq at zero", 32'(irqOut), 1);
    check(tcOut == 1, "R10 terminal pulse", 32'(tcOut), 1);
    idle(24);

    // one-shot, div 2, width 4, active-low
    wr(3, 4); wr(5, 1);
    wr(0, 1 | (1 << 5) | (2 << 6));
    wr(1, 32'h9);
    idle(40);
    checkCount(0, "R5 one-shot stops");
    check(irqOut == 1, "R4 low polarity idle", 32'(irqOut), 1);

    // free-running wrap
    wr(3, 2); wr(5, 1);
    wr(0, (2 << 2) | (1 << 6));
    wr(1, 32'h9);
    idle(4); checkCount(32'hFFFF_FFFF, "R5 free wrap");
    check(pwmOut == 0, "R3 free pwm stays low", 32'(pwmOut), 0);
    idle(5);

    // event counting, level interrupt
    wr(3, 3); wr(5, 9);
    wr(0, (3 << 2));
    wr(1, 32'h9);
    idle(3); checkCount(3, "R7 no strobe no step");
    wr(2, 1); idle(1); checkCount(2, "R7 one decrement");
    idle(3); checkCount(2, "R7 strobe self-clears");
    wr(2, 1); idle(1);
    wr(2, 1); idle(10);
    checkCount(0, "R7 reached zero");
    check(irqOut == 1, "R4 level held", 32'(irqOut), 1);
    wr(1, 32'hC); idle(1); #1;
    check(irqOut == 0, "R4 level cleared", 32'(irqOut), 0);

    // prescaler 16
    wr(3, 3); wr(5, 9);
    wr(0, 3 | (1 << 2) | (1 << 6));
    wr(1, 32'h9);
    idle(10); checkCount(3, "R6 hold before 16 clocks");
    idle(7);  checkCount(2, "R6 step after 16 clocks");

    // pause
    wr(3, 8); wr(0, (1 << 2) | (1 << 6));
    wr(1, 32'h9);
    idle(3);
    wr(1, 32'hA);
    #1; held = rdData;
    idle(10); checkCount(held, "R8 paused");
    wr(1, 32'h8); idle(5);

    // frozen read-back
    wr(1, 32'h0);
    #1; held = rdData;
    idle(8); checkCount(held, "R9 view frozen");
    wr(1, 32'h8); idle(3);

    // cascade steps
    wr(3, 20); wr(5, 0);
    wr(0, (1 << 8) | (1 << 2) | (1 << 6));
    wr(1, 32'h9);
    idle(5); checkCount(20, "R10 no cascade no step");
    cascadeIn = 1'b1; idle(3); cascadeIn = 1'b0;
    checkCount(17, "R10 three cascade steps");
    idle(3);

    // reserved mode never steps
    wr(0, (5 << 2));
    wr(1, 32'h9);
    idle(6); checkCount(20, "R5 reserved mode holds");
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule